// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that forces a system reset when software stops servicing it. A down-counter advances on ticks from a selectable clock divider. When it reaches zero, the block raises a one-cycle reset pulse on its output and reloads itself. Software talks to it over a simple 32-bit register bus. A dedicated command register accepts 16-bit magic words (upper half zero) that do four things: open and close write access to the divider and reload settings, arm the timer, and refresh it.

Changes to the divider and reload settings do not act at once. Each write raises a busy flag in the status word. The flag stays set for a fixed number of divider ticks, which stands in for the crossing into a slower counter clock. The new value reaches the counter only when the flag drops, so software polls the flag before relying on the setting. Once armed, the timer can only be stopped by the block reset.

Top module: `kwdog_top`

## Requirements
- R1: After reset, the divider setting (offset 0x04) reads 0, the reload setting (offset 0x08) reads 0xFFF, the status word (offset 0x0C) reads 0, and the reset output is low.
- R2: Writes to offsets 0x04 and 0x08 are ignored while access is closed. Access is closed after reset, is opened by writing 0x0000_5555 to offset 0x00, and is closed again by writing 0x0000_0000 there.
- R3: With access open, a write stores the value (3 bits at 0x04, 12 bits at 0x08) so that it reads back at once. The same write sets status bit 0 for the divider or status bit 1 for the reload.
- R4: A status busy bit clears after SYNC_TICKS divider ticks. The stored value becomes the active setting at that moment.
- R5: Writing 0x0000_CCCC to offset 0x00 arms the timer. The counter loads the active reload value R, the divider phase restarts, and the first reset pulse appears (R+1)×D clock cycles after the arming write.
- R6: Divider code c in 0..6 gives D = 4·2^c input cycles per tick. Code 7 acts as 256.
- R7: At expiry the reset output is high for exactly one cycle. The counter then reloads and keeps running, so pulses repeat every (R+1)×D cycles.
- R8: Writing 0x0000_AAAA to offset 0x00 reloads the counter and restarts the divider phase. The next pulse comes (R+1)×D cycles after that write.
- R9: A refresh accepted on the same edge as an expiry tick wins. No pulse is produced on that edge.
- R10: An armed timer is not stopped by any key value, including the close-access code. A key value outside the four codes has no effect, and in particular does not open access.
- R11: Reads of the command offset 0x00 and the window offset 0x10 return 0, and writes to 0x10 have no effect. Read data is registered and valid the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdog_rst_o | output | 1 | One-cycle reset pulse on expiry |

## Verification
A refresh and a counter expiry can land on the same clock edge, so the bench forces that collision. It arms the timer with a short period, computes the cycle of the expiry tick, and times the refresh write so that it is accepted on exactly that edge. The scoreboard then expects no pulse at the collision edge and one pulse a full period later. Any pulse at the collision edge is reported as unexpected.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
  localparam logic [31:0] KEY_OPEN  = 32'h0000_5555;
  localparam logic [31:0] KEY_CLOSE = 32'h0000_0000;
  localparam logic [31:0] KEY_ARM   = 32'h0000_CCCC;
  localparam logic [31:0] KEY_FEED  = 32'h0000_AAAA;

  localparam logic [4:0] OFS_KEY  = 5'h00;
  localparam logic [4:0] OFS_DIV  = 5'h04;
  localparam logic [4:0] OFS_RLD  = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_WIN  = 5'h10;

  // Last prescaler count for a divider code; codes above 6 saturate at /256.
  function automatic logic [7:0] div_last(input logic [2:0] code);
    logic [2:0] sat;
    logic [8:0] span;
    sat  = (code > 3'd6) ? 3'd6 : code;
    span = (9'd4 << sat) - 9'd1;
    return span[7:0];
  endfunction
endpackage

// File: rtl/kwdog_presc.sv
module kwdog_presc
  import kwdog_pkg::*;
#(
  parameter int PRE_W = 3,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [PRE_W-1:0] code,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last = DIV_W'(div_last(3'(code)));
  assign tick = (cnt_q == last) && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (cnt_q == last) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/kwdog_pend.sv
module kwdog_pend #(
  parameter int              DW         = 12,
  parameter int              SYNC_TICKS = 3,
  parameter logic [DW-1:0]   RST_VAL    = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  output logic [DW-1:0] shadow,
  output logic [DW-1:0] active,
  output logic          busy
);
  localparam int DC_W = $clog2(SYNC_TICKS + 1);
  logic [DC_W-1:0] dcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
      busy   <= 1'b0;
      dcnt_q <= '0;
    end else if (wr) begin
      shadow <= wdata;
      busy   <= 1'b1;
      dcnt_q <= '0;
    end else if (busy && tick) begin
      if (dcnt_q == DC_W'(SYNC_TICKS - 1)) begin
        active <= shadow;
        busy   <= 1'b0;
      end else begin
        dcnt_q <= dcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwdog_count.sv
module kwdog_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             feed,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      count   <= {CNT_W{1'b1}};
      pulse   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (arm) running <= 1'b1;
      if (arm || feed) begin
        count <= reload;
      end else if (running && tick) begin
        if (count == '0) begin
          pulse <= 1'b1;
          count <= reload;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int CNT_W      = 12,
  parameter int PRE_W      = 3,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdog_rst_o
);
  localparam int DIV_W = 8;

  logic             unlock_q;
  logic             key_wr, div_wr, rld_wr;
  logic             arm_go, feed_go, presc_clr, tick;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] div_sh, div_act;
  logic [CNT_W-1:0] rld_sh, rld_act;
  logic             div_busy, rld_busy;

  assign key_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_KEY));
  assign div_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_DIV)) && unlock_q;
  assign rld_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_RLD)) && unlock_q;
  assign arm_go  = key_wr && (bus_wdata == KEY_ARM) && !run_q;
  assign feed_go = key_wr && (bus_wdata == KEY_FEED);
  assign presc_clr = arm_go || feed_go;

  always_ff @(posedge clk) begin
    if (rst) unlock_q <= 1'b0;
    else if (key_wr && bus_wdata == KEY_OPEN) unlock_q <= 1'b1;
    else if (key_wr && bus_wdata == KEY_CLOSE) unlock_q <= 1'b0;
  end

  kwdog_presc #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst(rst), .clear(presc_clr), .code(div_act), .tick(tick)
  );

  kwdog_pend #(.DW(PRE_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL('0)) u_pend_div (
    .clk(clk), .rst(rst), .wr(div_wr), .wdata(bus_wdata[PRE_W-1:0]), .tick(tick),
    .shadow(div_sh), .active(div_act), .busy(div_busy)
  );

  kwdog_pend #(.DW(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RST_VAL({CNT_W{1'b1}})) u_pend_rld (
    .clk(clk), .rst(rst), .wr(rld_wr), .wdata(bus_wdata[CNT_W-1:0]), .tick(tick),
    .shadow(rld_sh), .active(rld_act), .busy(rld_busy)
  );

  kwdog_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .arm(arm_go), .feed(feed_go), .tick(tick),
    .reload(rld_act), .running(run_q), .count(cnt_q), .pulse(wdog_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_W'(OFS_DIV):  bus_rdata <= 32'(div_sh);
        ADDR_W'(OFS_RLD):  bus_rdata <= 32'(rld_sh);
        ADDR_W'(OFS_STAT): bus_rdata <= {30'd0, rld_busy, div_busy};
        default:           bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk
  import kwdog_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 12,
  parameter int PRE_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              wdog_rst_o,
  input logic              unlock_q,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [PRE_W-1:0]  div_sh,
  input logic [PRE_W-1:0]  div_act,
  input logic              div_busy,
  input logic [CNT_W-1:0]  rld_sh,
  input logic [CNT_W-1:0]  rld_act,
  input logic              rld_busy
);
  a_r2_locked_div: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_DIV) && !unlock_q) |=> $stable(div_sh));

  a_r2_locked_rld: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_RLD) && !unlock_q) |=> $stable(rld_sh));

  a_r4_div_applied: assert property (@(posedge clk) disable iff (rst)
    $fell(div_busy) |-> (div_act == div_sh));

  a_r4_rld_applied: assert property (@(posedge clk) disable iff (rst)
    $fell(rld_busy) |-> (rld_act == rld_sh));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_o |=> !wdog_rst_o);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> !wdog_rst_o);

  a_r10_no_stop: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);

  a_r9_feed_wins: assert property (@(posedge clk) disable iff (rst)
    (run_q && bus_wr && bus_addr == ADDR_W'(OFS_KEY) && bus_wdata == KEY_FEED)
    |=> (cnt_q == $past(rld_act)) && !wdog_rst_o);
endmodule

bind kwdog_top kwdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .wdog_rst_o(wdog_rst_o), .unlock_q(unlock_q), .run_q(run_q), .cnt_q(cnt_q),
  .div_sh(div_sh), .div_act(div_act), .div_busy(div_busy),
  .rld_sh(rld_sh), .rld_act(rld_act), .rld_busy(rld_busy)
);

// File: tb/kwdog_top_bench.sv
module kwdog_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_rst_o;

  localparam logic [4:0] A_KEY = 5'h00, A_DIV = 5'h04, A_RLD = 5'h08, A_STAT = 5'h0C, A_WIN = 5'h10;

  kwdog_top u_kwdog_top (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst_o(wdog_rst_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit prev_pulse = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected pulse edges and compares them with observed pulses.
  always @(negedge clk) begin
    if (!rst && wdog_rst_o) begin
      if (prev_pulse) chk(1'b0, "R7 pulse wider than one cycle", 2, 1);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 R9 unexpected pulse at edge", cyc, -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cyc == e.at, e.req, cyc, e.at);
      end
    end
    prev_pulse = wdog_rst_o;
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, output int edge_no);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    edge_no = cyc + 1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_at(input logic [4:0] a, input logic [31:0] d, input int edge_no);
    @(negedge clk);
    while (cyc < edge_no - 1) @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, req, int'(v), int'(exp));
  endtask

  task automatic poll_clear(input logic [31:0] mask, input string req);
    logic [31:0] v;
    int n = 0;
    v = mask;
    while ((v & mask) != 0 && n < 400) begin
      rd(A_STAT, v);
      n++;
    end
    chk((v & mask) == 0, req, int'(v & mask), 0);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input int at, input string req);
    exp_t e;
    e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  initial begin
    int e;
    int f;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(wdog_rst_o == 1'b0, "R1 output low after reset", int'(wdog_rst_o), 0);
    rd_chk(A_DIV, 32'd0, "R1 divider reset value");
    rd_chk(A_RLD, 32'hFFF, "R1 reload reset value");
    rd_chk(A_STAT, 32'd0, "R1 status reset value");
    rd_chk(A_KEY, 32'd0, "R11 key offset reads zero");

    // R2 closed access, R10 bogus key
    wr(A_DIV, 32'd1, e);
    rd_chk(A_DIV, 32'd0, "R2 divider write ignored while closed");
    rd_chk(A_STAT, 32'd0, "R2 no busy flag while closed");
    wr(A_KEY, 32'h0000_1234, e);
    wr(A_RLD, 32'd7, e);
    rd_chk(A_RLD, 32'hFFF, "R10 undefined key does not open access");

    // R3 R4 R11 open access and update
    wr(A_KEY, 32'h0000_5555, e);
    wr(A_WIN, 32'h55, e);
    rd_chk(A_WIN, 32'd0, "R11 window offset reads zero");
    wr(A_RLD, 32'd5, e);
    rd_chk(A_STAT, 32'd2, "R3 reload busy bit 1 set");
    rd_chk(A_RLD, 32'd5, "R3 reload readback");
    poll_clear(32'd2, "R4 reload busy clears");
    wr(A_KEY, 32'h0000_0000, e);
    wr(A_RLD, 32'd9, e);
    rd_chk(A_RLD, 32'd5, "R2 access closed again");

    // R5 R7 R10 arm, period 6*4, auto-reload, cannot stop
    wr(A_KEY, 32'h0000_CCCC, e);
    push(e + 24, "R5 first pulse time");
    push(e + 48, "R7 repeat pulse time");
    wr(A_KEY, 32'h0000_0000, f);
    wr(A_KEY, 32'h0000_9999, f);
    drain("R10 timer keeps running");
    do_reset();

    // R6 code 1, R8 refresh
    wr(A_KEY, 32'h0000_5555, e);
    wr(A_DIV, 32'd1, e);
    rd_chk(A_STAT, 32'd1, "R3 divider busy bit 0 set");
    rd_chk(A_DIV, 32'd1, "R3 divider readback");
    poll_clear(32'd1, "R4 divider busy clears");
    wr(A_RLD, 32'd3, e);
    poll_clear(32'd2, "R4 reload busy clears");
    wr(A_KEY, 32'h0000_CCCC, e);
    push(e + 32, "R6 code 1 period");
    drain("R6 pulse seen");
    repeat (10) @(negedge clk);
    wr(A_KEY, 32'h0000_AAAA, f);
    push(f + 32, "R8 pulse after refresh");
    drain("R8 pulse seen");
    do_reset();

    // R6 code 2
    wr(A_KEY, 32'h0000_5555, e);
    wr(A_DIV, 32'd2, e);
    poll_clear(32'd1, "R4 divider busy clears");
    wr(A_RLD, 32'd1, e);
    poll_clear(32'd2, "R4 reload busy clears");
    wr(A_KEY, 32'h0000_CCCC, e);
    push(e + 32, "R6 code 2 period");
    drain("R6 pulse seen");
    do_reset();

    // R9 refresh on the expiry edge
    wr(A_KEY, 32'h0000_5555, e);
    wr(A_RLD, 32'd5, e);
    poll_clear(32'd2, "R4 reload busy clears");
    wr(A_KEY, 32'h0000_CCCC, e);
    wr_at(A_KEY, 32'h0000_AAAA, e + 24);
    push(e + 48, "R9 refresh wins, pulse one period later");
    drain("R9 pulse seen");
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule